// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap

This block is the integer execute stage of a small load/store processor core. Each cycle it may accept one operation. The operation carries two 32-bit register values, a 16-bit immediate, a flag that puts the immediate in place of the second register, a 4-bit operation code, and, for loads, the aligned 32-bit memory word and the low two address bits. One clock later it presents a full 32-bit result, a write-enable for the destination register and a single-cycle overflow-trap flag.

The operation code alone decides how the immediate is widened, which loads are sign-extended and which additions trap. The trapping forms are signed add and signed subtract. The non-trapping forms are unsigned add and subtract, the four logical operations, load-upper, the two logical shifts and all loads. When a trap is raised, the write-enable stays low for that result, so the destination register keeps its old value.

Top module: `risc_exec_unit`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `res_valid`, `wr_en`, `ovf_trap` and `result` are all zero.
- R2: The result for an operation appears one clock after it is presented. `res_valid` equals the previous cycle's `in_valid`. A cycle with `in_valid` low gives `wr_en` and `ovf_trap` low on the next cycle.
- R3: Signed add (op 0) and signed subtract (op 2) raise `ovf_trap` for exactly that result when the true two's-complement result falls outside the 32-bit range, and `wr_en` is then low. Without overflow, `wr_en` is high and `ovf_trap` is low.
- R4: Unsigned add (op 1), unsigned subtract (op 3), the logical operations, load-upper, the shifts and the loads never raise `ovf_trap`. Every valid result of these operations has `wr_en` high. Unsigned add and subtract wrap modulo 2^32.
- R5: With `use_imm` high, the second operand is the immediate. For ops 0–3 the immediate is sign-extended from bit 15. For ops 4–7 and the shifts it is zero-extended.
- R6: Op 4 gives AND, op 5 gives OR, op 6 gives XOR and op 7 gives NOR of the first operand and the selected second operand.
- R7: Load-upper (op 8) gives `{imm, 16'h0000}`, whatever the values of `use_imm` and the register inputs.
- R8: Op 9 shifts `rs_val` left and op 10 shifts it right logically, filling with zeros. The shift amount is `imm[4:0]` when `use_imm` is high and `rt_val[4:0]` otherwise.
- R9: Byte loads take byte `addr_lo` of `mem_word`, where byte 0 is bits 7:0 (little-endian). Op 11 sign-extends the byte to 32 bits and op 12 zero-extends it.
- R10: Halfword loads take bits 15:0 of `mem_word` when `addr_lo[1]` is 0 and bits 31:16 when it is 1. `addr_lo[0]` is ignored. Op 13 sign-extends the halfword and op 14 zero-extends it. Op 15 passes `mem_word` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (0–15, see requirements) |
| use_imm | input | 1 | Select the immediate as the second operand |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| mem_word | input | 32 | Aligned memory word for loads |
| addr_lo | input | 2 | Low address bits for loads |
| res_valid | output | 1 | Result registers hold a new operation |
| result | output | 32 | 32-bit result |
| wr_en | output | 1 | Destination may be written |
| ovf_trap | output | 1 | Overflow exception, one cycle |

## Verification
The only state is the output register stage. A wrong extension choice, a wrong operand select or a faulty overflow term therefore shows at the ports on the cycle right after the offending operation, as a wrong `result` word or a flipped `wr_en`/`ovf_trap` pair. A stuck or wrongly reset register shows on the first compare after reset. The reference model flags any such fault within one clock, because it compares every cycle. Values on the range limits (±2^31), immediates with bit 15 set, every byte offset and the ignored `addr_lo[0]` are driven directly to make these faults visible.

// File: rtl/risc_exec_unit.sv
module risc_exec_unit #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic          use_imm,
  input  logic [W-1:0]  rs_val,
  input  logic [W-1:0]  rt_val,
  input  logic [IW-1:0] imm,
  input  logic [W-1:0]  mem_word,
  input  logic [1:0]    addr_lo,
  output logic          res_valid,
  output logic [W-1:0]  result,
  output logic          wr_en,
  output logic          ovf_trap
);
  localparam int SW = $clog2(W);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADDU = 4'd1, OP_SUB = 4'd2, OP_SUBU = 4'd3,
                         OP_AND = 4'd4, OP_OR = 4'd5, OP_XOR = 4'd6, OP_NOR = 4'd7,
                         OP_LUI = 4'd8, OP_SLL = 4'd9, OP_SRL = 4'd10, OP_LB = 4'd11,
                         OP_LBU = 4'd12, OP_LH = 4'd13, OP_LHU = 4'd14, OP_LW = 4'd15;

  logic          arith, is_sub, trap_op, ovf;
  logic [W-1:0]  imm_x, opb, b_eff, sum, nxt, byte_w;
  logic [7:0]    byte_v;
  logic [15:0]   half_v;

  assign arith   = (op == OP_ADD) || (op == OP_ADDU) || (op == OP_SUB) || (op == OP_SUBU);
  assign is_sub  = (op == OP_SUB) || (op == OP_SUBU);
  assign trap_op = (op == OP_ADD) || (op == OP_SUB);

  assign imm_x = arith ? {{(W-IW){imm[IW-1]}}, imm} : {{(W-IW){1'b0}}, imm};
  assign opb   = use_imm ? imm_x : rt_val;
  assign b_eff = is_sub ? ~opb : opb;
  assign sum   = rs_val + b_eff + {{(W-1){1'b0}}, is_sub};
  assign ovf   = trap_op && (rs_val[W-1] == b_eff[W-1]) && (sum[W-1] != rs_val[W-1]);

  assign byte_w = mem_word >> {addr_lo, 3'b000};
  assign byte_v = byte_w[7:0];
  assign half_v = addr_lo[1] ? mem_word[31:16] : mem_word[15:0];

  always_comb begin
    case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: nxt = sum;
      OP_AND:  nxt = rs_val & opb;
      OP_OR:   nxt = rs_val | opb;
      OP_XOR:  nxt = rs_val ^ opb;
      OP_NOR:  nxt = ~(rs_val | opb);
      OP_LUI:  nxt = {imm, {(W-IW){1'b0}}};
      OP_SLL:  nxt = rs_val << opb[SW-1:0];
      OP_SRL:  nxt = rs_val >> opb[SW-1:0];
      OP_LB:   nxt = {{(W-8){byte_v[7]}}, byte_v};
      OP_LBU:  nxt = {{(W-8){1'b0}}, byte_v};
      OP_LH:   nxt = {{(W-16){half_v[15]}}, half_v};
      OP_LHU:  nxt = {{(W-16){1'b0}}, half_v};
      default: nxt = mem_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      ovf_trap  <= 1'b0;
    end else begin
      res_valid <= in_valid;
      wr_en     <= in_valid && !ovf;
      ovf_trap  <= in_valid && ovf;
      if (in_valid) result <= nxt;
    end
  end

  a_r3_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (wr_en ^ ovf_trap));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && !wr_en && !ovf_trap));
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != OP_ADD && op != OP_SUB) |=> !ovf_trap);
  a_r7_lui_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_LUI) |=> (result[IW-1:0] == '0 && result[W-1:W-IW] == $past(imm)));
  a_r9_lbu_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_LBU) |=> (result[W-1:8] == '0));
endmodule

// File: tb/risc_exec_unit_tb.sv
module risc_exec_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, use_imm = 1'b0;
  logic [3:0] op = 4'd0;
  logic [31:0] rs_val = '0, rt_val = '0, mem_word = '0;
  logic [15:0] imm = '0;
  logic [1:0] addr_lo = '0;
  logic res_valid, wr_en, ovf_trap;
  logic [31:0] result;

  int checks = 0, errors = 0;
  bit done = 0;
  logic exp_v = 1'b0, exp_trap = 1'b0;
  logic [31:0] exp_res = '0;
  string exp_tag = "R2";

  always #10 clk = ~clk;

  risc_exec_unit u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_imm(use_imm),
    .rs_val(rs_val), .rt_val(rt_val), .imm(imm), .mem_word(mem_word), .addr_lo(addr_lo),
    .res_valid(res_valid), .result(result), .wr_en(wr_en), .ovf_trap(ovf_trap));

  function automatic string tag_of(input int o, input bit ui);
    if (ui && o <= 7) return "R5";
    if (o == 0 || o == 2) return "R3";
    if (o == 1 || o == 3) return "R4";
    if (o <= 7) return "R6";
    if (o == 8) return "R7";
    if (o <= 10) return "R8";
    if (o <= 12) return "R9";
    return "R10";
  endfunction

  task automatic model(input int o, input bit ui, input logic [31:0] a, input logic [31:0] rt,
                       input logic [15:0] im, input logic [31:0] mw, input int al);
    longint sa, sb, s;
    logic [31:0] b;
    int bytev, halfv;
    if (o <= 3) b = ui ? 32'($signed(im)) : rt;
    else b = ui ? {16'h0, im} : rt;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    exp_trap = 1'b0;
    bytev = int'((mw >> (8 * al)) & 32'hFF);
    halfv = (al >= 2) ? int'(mw[31:16]) : int'(mw[15:0]);
    case (o)
      0, 1: begin s = sa + sb; exp_res = 32'(s); exp_trap = (o == 0) && (s > 64'sd2147483647 || s < -64'sd2147483648); end
      2, 3: begin s = sa - sb; exp_res = 32'(s); exp_trap = (o == 2) && (s > 64'sd2147483647 || s < -64'sd2147483648); end
      4: exp_res = a & b;
      5: exp_res = a | b;
      6: exp_res = a ^ b;
      7: exp_res = ~(a | b);
      8: exp_res = {im, 16'h0};
      9: exp_res = a << (b % 32);
      10: exp_res = a >> (b % 32);
      11: exp_res = 32'(bytev >= 128 ? bytev - 256 : bytev);
      12: exp_res = 32'(bytev);
      13: exp_res = 32'(halfv >= 32768 ? halfv - 65536 : halfv);
      14: exp_res = 32'(halfv);
      default: exp_res = mw;
    endcase
  endtask

  task automatic compare();
    checks++;
    if (res_valid !== exp_v || wr_en !== (exp_v && !exp_trap) || ovf_trap !== (exp_v && exp_trap)) begin
      errors++;
      $display("FAIL %s flags: valid/wr/trap=%b%b%b expected %b%b%b", exp_v ? exp_tag : "R2",
               res_valid, wr_en, ovf_trap, exp_v, exp_v && !exp_trap, exp_v && exp_trap);
    end
    if (exp_v) begin
      checks++;
      if (result !== exp_res) begin
        errors++;
        $display("FAIL %s result: got %h expected %h", exp_tag, result, exp_res);
      end
    end
  endtask

  task automatic step(input bit v, input int o, input bit ui, input logic [31:0] a, input logic [31:0] rt,
                      input logic [15:0] im, input logic [31:0] mw, input int al);
    @(negedge clk);
    compare();
    in_valid = v; op = 4'(o); use_imm = ui; rs_val = a; rt_val = rt; imm = im; mem_word = mw; addr_lo = 2'(al);
    exp_v = v;
    exp_tag = tag_of(o, ui);
    model(o, ui, a, rt, im, mw, al);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 0 || wr_en !== 0 || ovf_trap !== 0 || result !== 0) begin
      errors++;
      $display("FAIL R1 reset: %b%b%b %h expected 000 00000000", res_valid, wr_en, ovf_trap, result);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (res_valid !== 0 || wr_en !== 0 || ovf_trap !== 0 || result !== 0) begin
      errors++;
      $display("FAIL R1 after reset: %b%b%b %h expected 000 00000000", res_valid, wr_en, ovf_trap, result);
    end
    // R3 signed overflow at both range ends
    step(1, 0, 0, 32'h7FFFFFFF, 32'h1, 0, 0, 0);
    step(1, 0, 0, 32'h80000000, 32'hFFFFFFFF, 0, 0, 0);
    step(1, 2, 0, 32'h80000000, 32'h1, 0, 0, 0);
    step(1, 2, 0, 32'h0, 32'h80000000, 0, 0, 0);
    step(1, 2, 0, 32'hFFFFFFFF, 32'h80000000, 0, 0, 0);
    step(1, 0, 0, 32'h7FFFFFFE, 32'h1, 0, 0, 0);
    // R4 unsigned forms wrap without trap
    step(1, 1, 0, 32'h7FFFFFFF, 32'h1, 0, 0, 0);
    step(1, 3, 0, 32'h80000000, 32'h1, 0, 0, 0);
    step(0, 0, 0, 32'h7FFFFFFF, 32'h1, 0, 0, 0);
    // R5 immediate extension
    step(1, 0, 1, 32'd5, 0, 16'hFFFF, 0, 0);
    step(1, 1, 1, 32'd0, 0, 16'h8000, 0, 0);
    step(1, 5, 1, 32'h0, 0, 16'hFFFF, 0, 0);
    step(1, 4, 1, 32'hFFFFFFFF, 0, 16'h8001, 0, 0);
    step(1, 0, 1, 32'h7FFFFFFF, 0, 16'h0001, 0, 0);
    // R6 logical
    step(1, 6, 0, 32'hF0F0F0F0, 32'hFF00FF00, 0, 0, 0);
    step(1, 7, 0, 32'h0F0F0000, 32'h000000F0, 0, 0, 0);
    // R7 load-upper ignores registers and select
    step(1, 8, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hABCD, 0, 0);
    step(1, 8, 1, 32'h12345678, 0, 16'h8000, 0, 0);
    // R8 shifts
    step(1, 9, 1, 32'h1, 0, 16'h001F, 0, 0);
    step(1, 10, 1, 32'h80000000, 0, 16'hFFE4, 0, 0);
    step(1, 10, 0, 32'hF0000000, 32'hFFFFFF21, 0, 0, 0);
    // R9 bytes, every offset
    for (int k = 0; k < 4; k++) begin
      step(1, 11, 0, 0, 0, 0, 32'h80FF7F01, k);
      step(1, 12, 0, 0, 0, 0, 32'h80FF7F01, k);
    end
    // R10 halfwords, addr_lo[0] ignored, word pass-through
    for (int k = 0; k < 4; k++) begin
      step(1, 13, 0, 0, 0, 0, 32'h8001_7FFE, k);
      step(1, 14, 0, 0, 0, 0, 32'h8001_7FFE, k);
    end
    step(1, 15, 0, 0, 0, 0, 32'hDEADBEEF, 3);
    for (int n = 0; n < 600; n++) begin
      int o;
      logic [31:0] a, b;
      o = int'($urandom % 16);
      a = (n % 5 == 0) ? {$urandom % 2 == 0 ? 1'b0 : 1'b1, 31'h7FFFFFFF ^ 31'($urandom % 4)} : 32'($urandom);
      b = 32'($urandom);
      step(($urandom % 8) != 0, o, $urandom % 2 == 1, a, b, 16'($urandom), 32'($urandom), int'($urandom % 4));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule